// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Result Reader

This block sits on the host side of a delta-sigma converter. It collects each conversion result over a frame-synchronous serial link. The converter pulls its active-low ready line low when a new result is waiting. The reader passes that line through a two-flop synchronizer and detects the falling edge. It then waits a fixed holdoff of master-clock cycles, and after that it generates a serial clock and shifts in the frame most significant bit first.

The serial clock runs at the master clock divided by `2^DIV_EXP`, with `DIV_EXP` at least 1, so each high and low phase lasts `2^(DIV_EXP-1)` master clocks. Several converters can be chained. In that case one frame carries `N_WORDS` results of 24 bits each, and each result appears on its own single-cycle valid strobe. While the frame shifts in, the reader drives a chain-input line with a pattern taken at frame start. The last device in the chain reads that line on serial-clock falling edges.

A ready edge that arrives while a frame is still running does not start a new frame. It sets a sticky overrun flag, and the running frame finishes.

Top module: `adc_frame_reader`

## Requirements
- R1: Synchronous active-high reset puts the block in idle with `sclk_o`, `din_o`, `word_valid_o` and `overrun_o` all low.
- R2: The ready line passes two synchronizing flops and then a falling-edge detector, followed by a holdoff of `HOLD_CYC` (default 1) master clocks. The first rising edge of `sclk_o` is therefore registered on the clock edge that comes 2+`HOLD_CYC`+`2^(DIV_EXP-1)` edges after the first clock edge that samples `drdy_n_i` low. With the defaults that is the fourth edge after.
- R3: `sclk_o` idles low between frames. During a frame, each high phase and each low phase lasts exactly `2^(DIV_EXP-1)` master clocks.
- R4: The reader samples `dout_i` on the clock edge that raises `sclk_o`, most significant bit first. One frame has exactly 24·`N_WORDS` rising edges.
- R5: Each group of 24 samples forms one word, with the first sample at bit 23. The word appears on `word_o` with `word_valid_o` high for one cycle, starting on the edge that captures its bit 0. Words arrive in the order they were shifted. `word_o` keeps its value until the next word.
- R6: `chain_pattern_i` is latched when the frame starts and is driven on `din_o` from bit 24·`N_WORDS`-1 down to bit 0. Each bit is updated on the edge that raises `sclk_o` and stays stable while `sclk_o` is high. `din_o` is low when the block is idle.
- R7: The ready line going high during a frame has no effect. The frame still clocks all of its bits.
- R8: A ready falling edge detected while a frame is in holdoff or shifting sets `overrun_o`, which stays high until reset. The running frame completes, and that edge starts no further frame.
- R9: `word_valid_o` is never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| drdy_n_i | input | 1 | Asynchronous active-low result-ready line from the converter |
| dout_i | input | 1 | Serial data from the converter; changes after serial-clock falling edges |
| chain_pattern_i | input | 24·N_WORDS | Bits to send on the chain-input line during the next frame |
| sclk_o | output | 1 | Generated serial clock |
| din_o | output | 1 | Chain-input line toward the last chained converter |
| word_valid_o | output | 1 | One-cycle strobe that marks a new word on `word_o` |
| word_o | output | 24 | Most recent assembled result word |
| overrun_o | output | 1 | Sticky flag for a ready edge that arrived during a frame |

## Verification
The bench drives every input just after a falling clock edge and reads outputs at the next falling edges. Each registered result is therefore seen half a cycle after the edge that produced it. With the defaults, the first `sclk_o` high is due at the fifth falling edge after `drdy_n_i` is lowered: two synchronizer edges, one edge-detect edge, one holdoff edge and one low phase. The bench counts those edges rather than waiting for the event. A bench-side converter model moves its data one bit on every observed serial-clock fall. It compares the assembled words and the chain-line bits when each one appears, and the phase lengths are measured in whole falling-edge samples. Checks for overrun and idle behaviour come a fixed number of cycles after the frame's last fall, so a new frame that starts by mistake is seen as a stray serial-clock edge.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    // Width of one converter result.
    localparam int WORD_W = 24;

    typedef logic [WORD_W-1:0] adc_word_t;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SHIFT = 2'd2
    } frame_st_e;

    // Serial-clock edges that the next master-clock edge will produce.
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    // Master clocks per serial-clock phase for a given divider exponent.
    function automatic int phase_cycles(input int div_exp);
        if (div_exp < 1) begin
            return 1;
        end
        return 1 << (div_exp - 1);
    endfunction

    // Counter width that holds values 0..n.
    function automatic int cnt_width(input int n);
        if (n < 2) begin
            return 1;
        end
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/adcrd_drdy_sync.sv
module adcrd_drdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= drdy_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= sync_q[STAGES-1];
    end

    assign fall_o = last_q & ~sync_q[STAGES-1];

    // R2: the edge detector yields one strobe per falling edge
    p_fall_single_r2: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen
    import adcrd_pkg::*;
#(
    parameter int DIV_EXP = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    output logic      sclk_o,
    output sclk_evt_t evt_o
);
    localparam int HALF = phase_cycles(DIV_EXP);
    localparam int CW   = cnt_width(HALF);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          last_tick;

    assign last_tick  = (cnt_q == CW'(HALF - 1));
    assign evt_o.rise = run_i & ~sclk_q & last_tick;
    assign evt_o.fall = run_i &  sclk_q & last_tick;
    assign sclk_o     = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (last_tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Checker: length of the phase that just ended.
    logic          prev_q;
    logic [CW:0]   len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            len_q  <= (CW+1)'(HALF);
        end else begin
            prev_q <= sclk_q;
            if (sclk_q != prev_q)              len_q <= (CW+1)'(1);
            else if (len_q < (CW+1)'(HALF))    len_q <= len_q + 1'b1;
        end
    end

    // R3: no serial-clock phase is shorter than the configured length
    p_phase_min_r3: assert property (@(posedge clk) disable iff (rst)
        (sclk_q != prev_q) |-> (len_q >= (CW+1)'(HALF)));

    // R3: the serial clock sits low while the generator is stopped
    p_stop_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !$past(run_i)) |-> !sclk_o);

endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter
    import adcrd_pkg::*;
#(
    parameter int FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  logic               load_i,
    input  logic               rise_i,
    input  logic [FRAME_W-1:0] pattern_i,
    input  logic               dout_i,
    output logic               din_o,
    output logic               valid_o,
    output adc_word_t          word_o
);
    localparam int WCW = cnt_width(WORD_W - 1);

    logic [WORD_W-2:0]  rx_q;
    logic [FRAME_W-1:0] tx_q;
    logic [WCW-1:0]     wcnt_q;
    logic               word_done;

    assign word_done = (wcnt_q == WCW'(WORD_W - 1));

    // Receive side: assemble words from converter samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            wcnt_q  <= '0;
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            if (load_i) begin
                wcnt_q <= '0;
            end else if (rise_i) begin
                rx_q <= {rx_q[WORD_W-3:0], dout_i};
                if (word_done) begin
                    word_o  <= {rx_q, dout_i};
                    valid_o <= 1'b1;
                    wcnt_q  <= '0;
                end else begin
                    wcnt_q  <= wcnt_q + 1'b1;
                end
            end
        end
    end

    // Transmit side: chain-input pattern, launched with each rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            din_o <= 1'b0;
        end else if (load_i) begin
            tx_q  <= pattern_i;
            din_o <= 1'b0;
        end else if (!active_i) begin
            din_o <= 1'b0;
        end else if (rise_i) begin
            din_o <= tx_q[FRAME_W-1];
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // R5: every word strobe lasts a single cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_EXP  = 1,
    parameter int N_WORDS  = 2,
    parameter int HOLD_CYC = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          drdy_n_i,
    input  logic                          dout_i,
    input  logic [WORD_W*N_WORDS-1:0]     chain_pattern_i,
    output logic                          sclk_o,
    output logic                          din_o,
    output logic                          word_valid_o,
    output logic [WORD_W-1:0]             word_o,
    output logic                          overrun_o
);
    localparam int FRAME_W = WORD_W * N_WORDS;
    localparam int BCW     = cnt_width(FRAME_W);
    localparam int HCW     = cnt_width(HOLD_CYC);

    frame_st_e      st_q;
    logic [BCW-1:0] bit_cnt_q;
    logic [HCW-1:0] hold_cnt_q;
    logic           ovr_q;
    logic           ready_fall;
    logic           run;
    logic           active;
    logic           load;
    sclk_evt_t      evt;

    adcrd_drdy_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .drdy_n_i (drdy_n_i),
        .fall_o   (ready_fall)
    );

    assign run    = (st_q == ST_SHIFT);
    assign active = (st_q != ST_IDLE);
    assign load   = (st_q == ST_IDLE) && ready_fall;

    adcrd_sclk_gen #(.DIV_EXP(DIV_EXP)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .sclk_o (sclk_o),
        .evt_o  (evt)
    );

    adcrd_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .load_i    (load),
        .rise_i    (evt.rise),
        .pattern_i (chain_pattern_i),
        .dout_i    (dout_i),
        .din_o     (din_o),
        .valid_o   (word_valid_o),
        .word_o    (word_o)
    );

    // Frame sequencer.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            bit_cnt_q  <= '0;
            hold_cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (ready_fall) begin
                        st_q       <= ST_HOLD;
                        hold_cnt_q <= '0;
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt_q == HCW'(HOLD_CYC - 1)) begin
                        st_q      <= ST_SHIFT;
                        bit_cnt_q <= '0;
                    end else begin
                        hold_cnt_q <= hold_cnt_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (evt.rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (evt.fall && bit_cnt_q == BCW'(FRAME_W)) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky overrun on a ready edge during a frame.
    always_ff @(posedge clk) begin
        if (rst)                      ovr_q <= 1'b0;
        else if (ready_fall && active) ovr_q <= 1'b1;
    end

    assign overrun_o = ovr_q;

    // R8: the overrun flag never clears without reset
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    // R2: no serial-clock activity during the holdoff
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> !sclk_o);

    // R3: serial clock stays low across idle
    p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !sclk_o);

    // R6: chain line holds steady through each high phase
    p_din_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(din_o));

    // R4: the bit counter never passes the frame length
    p_frame_bits_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> (bit_cnt_q <= BCW'(FRAME_W)));

    // R9: no word strobe while idle
    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !word_valid_o);

endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_EXP    = 1;
    localparam int N_WORDS    = 2;
    localparam int FW         = 24 * N_WORDS;
    localparam int HALF       = 1 << (DIV_EXP - 1);
    localparam int FIRST_RISE = 4 + HALF;  // falling-edge samples until first high

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          drdy_n = 1'b1;
    logic          dout = 1'b0;
    logic [FW-1:0] pattern = '0;
    logic          sclk, din, wvalid, ovr;
    logic [23:0]   word;

    int errors = 0;
    int checks = 0;

    // bench-side converter and observation state
    logic [FW-1:0] adc_sr;
    logic [FW-1:0] din_cap;
    logic [23:0]   got [N_WORDS];
    int  rises, first_rise, stepno, len, phase_bad, nwords, valid_dbl;
    bit  sclk_q, valid_q, released, inject;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_reader #(.DIV_EXP(DIV_EXP), .N_WORDS(N_WORDS), .HOLD_CYC(1)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .drdy_n_i        (drdy_n),
        .dout_i          (dout),
        .chain_pattern_i (pattern),
        .sclk_o          (sclk),
        .din_o           (din),
        .word_valid_o    (wvalid),
        .word_o          (word),
        .overrun_o       (ovr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One falling-edge sample plus converter model update.
    task automatic step();
        @(negedge clk);
        stepno++;
        if (wvalid) begin
            if (valid_q) valid_dbl++;
            if (nwords < N_WORDS) got[nwords] = word;
            nwords++;
        end
        valid_q = wvalid;
        if (sclk && !sclk_q) begin
            rises++;
            if (rises == 1) first_rise = stepno;
            else if (len != HALF) phase_bad++;
            din_cap = {din_cap[FW-2:0], din};
            len = 1;
            if (inject && rises == 30) drdy_n = 1'b0;
            if (inject && rises == 32) drdy_n = 1'b1;
        end else if (!sclk && sclk_q) begin
            if (len != HALF) phase_bad++;
            len = 1;
            adc_sr = {adc_sr[FW-2:0], 1'b0};
            dout = adc_sr[FW-1];
            if (!released) begin
                drdy_n = 1'b1;   // R7: ready returns high mid-frame
                released = 1'b1;
            end
        end else begin
            len++;
        end
        sclk_q = sclk;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1", "sclk after reset", sclk, 0);
        chk("R1", "din after reset", din, 0);
        chk("R1", "valid after reset", wvalid, 0);
        chk("R1", "overrun after reset", ovr, 0);
        rst = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_frame(input string tag, input logic [23:0] w0, input logic [23:0] w1,
                           input logic [FW-1:0] pat, input bit inj, input bit exp_ovr);
        rises = 0; first_rise = 0; stepno = 0; len = 0; phase_bad = 0;
        nwords = 0; valid_dbl = 0; released = 1'b0; inject = inj;
        din_cap = '0; got[0] = '0; got[1] = '0;
        pattern = pat;
        adc_sr = {w0, w1};
        dout = adc_sr[FW-1];
        drdy_n = 1'b0;
        for (int i = 0; i < 1000 && !(rises == FW && !sclk); i++) step();
        repeat (20) step();
        $display("frame %s done", tag);
        chk("R2", "first rise sample", first_rise, FIRST_RISE);
        chk("R4", "rising edges in frame", rises, FW);
        chk("R7", "ready release ignored", released && rises == FW, 1);
        chk("R3", "phase length violations", phase_bad, 0);
        chk("R5", "word count", nwords, N_WORDS);
        chk("R5", "word 0", got[0], w0);
        chk("R5", "word 1", got[1], w1);
        chk("R5", "strobe wider than one cycle", valid_dbl, 0);
        chk("R5", "word held after frame", word, w1);
        chk("R6", "chain line bits", din_cap, pat);
        chk("R6", "chain line idle", din, 0);
        chk("R3", "sclk idle after frame", sclk, 0);
        chk("R8", "overrun flag", ovr, exp_ovr);
        inject = 1'b0;
    endtask

    // R8: flagged edge starts no extra frame
    task automatic t_no_extra_frame();
        rises = 0;
        repeat (40) step();
        chk("R8", "rises after overrun frame", rises, 0);
        chk("R9", "valid while idle", wvalid, 0);
    endtask

    task automatic t_reset_clears();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        step();
        chk("R1", "overrun cleared by reset", ovr, 0);
        chk("R1", "sclk low after reset", sclk, 0);
        repeat (3) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        sclk_q = 1'b0; valid_q = 1'b0; inject = 1'b0;
        t_reset();
        t_frame("basic", 24'hA5C3F0, 24'h0F1E2D, {24'h123456, 24'hFEDCBA}, 0, 0);
        t_frame("edges", 24'h800001, 24'h7FFFFE, '1, 0, 0);
        t_frame("zeros", 24'h000000, 24'hFFFFFF, '0, 0, 0);
        t_frame("overrun", 24'h3C3C3C, 24'hC3C3C3, {24'hAAAAAA, 24'h555555}, 1, 1);
        t_no_extra_frame();
        t_frame("after", 24'h13579B, 24'h2468AC, {24'h0000FF, 24'hF00000}, 0, 1);
        t_reset_clears();
        t_frame("clean", 24'h6B1D2E, 24'h9E4F70, {24'h5A5A5A, 24'hA5A5A5}, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule